// File: doc/BRIEF.md
# DSI Video Blanking Calculator

This block turns a panel's horizontal and vertical timing, given in pixels and lines, into the blanking word counts that a DSI video-mode packet generator needs. It converts the horizontal sync width and the two horizontal porches into byte counts for the chosen pixel format. It then removes the cost of the high-speed entry and exit sequence from the porches, sharing that cost out in proportion to their sizes. Where the line-end mode asks for it, it aligns the counts to the lane count, and it enforces a minimum size on each porch. The vertical line counts and the pixel-stream word count come out alongside.

The caller places every input on the ports and pulses `start` for one cycle. The inputs are captured on that edge and may then change. After a fixed sequence of states (IDLE, LOAD, DIVF, DIVB, ALIGN, BAL) the block pulses `done` for one cycle. Its outputs change in the same cycle and then hold until the next result. The two proportional shares are found by one restoring divider that the DIVF and DIVB states use in turn.

The state transitions are as follows:
- IDLE goes to LOAD on `start`.
- LOAD goes to DIVF when the overhead can be removed, and to ALIGN otherwise.
- DIVF goes to DIVB when the first quotient is ready.
- DIVB goes to ALIGN when the second quotient is ready.
- ALIGN always goes to BAL.
- BAL always goes to IDLE.

Top module: `dsi_blank_calc`

## Requirements
- R1: Bytes per pixel is 2 for `fmt`=3 (16-bit colour). It is 3 for `fmt`=0 (24-bit), `fmt`=1 (18-bit in 24-bit containers) and `fmt`=2 (packed 18-bit), and 3 for every other code.
- R2: `vsa_ln`=vsync width, `vbp_ln`=vblank-vsync_off-vsync_w-vborder, `vfp_ln`=vsync_off-vborder, `vact_ln`=vactive.
- R3: Let hbp=hblank-hsync_off-hsync_w-hborder and hfp=hsync_off-hborder (pixels), and B the bytes per pixel. The base counts are hsa=hsync_w*B-10 and hfp_b=hfp*B. hbp_b is hbp*B-10 when `sync_pulse`=1, and (hbp+hsync_w)*B-10 otherwise.
- R4: The overhead is `dphy_ovr` when that is nonzero. Otherwise it is (lpx+hs_prep+hs_zero+hs_exit+3)*L+10, plus 2 if `eot_pkt`, plus 6 if `burst`. L is `lanes` when 1 to 4, and 4 for any other value.
- R5: When hfp>=0, hbp>=0 and (hfp+hbp)*B exceeds the overhead, floor(ovh*hfp/(hfp+hbp)) is subtracted from hfp_b and floor(ovh*hbp/(hfp+hbp)) from hbp_b, and `warn_ovh`=0. Otherwise the counts are left as they are and `warn_ovh`=1.
- R6: With `line_end`=1, each of hsa, hfp_b and hbp_b is rounded up to the next multiple of L and then reduced by 2. hbp_b is then further reduced by (hactive*B+2) mod L.
- R7: If hfp_b+hbp_b<4, `err_porch`=1 and both counts are left unchanged. Otherwise, if hfp_b<2, hbp_b loses 2-hfp_b and hfp_b becomes 2. Otherwise, if hbp_b<2, hfp_b loses 2-hbp_b and hbp_b becomes 2.
- R8: `ps_wc` is the low 16 bits of hactive*B.
- R9: `done` is a single-cycle pulse, one per accepted `start`. A `start` during a computation is ignored. The outputs change only in the cycle in which `done` is high.
- R10: After reset, `done`, all counts and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation (one-cycle pulse, accepted only when idle) |
| fmt | input | 3 | Pixel format code |
| lanes | input | 3 | Data lane count, 1 to 4 |
| sync_pulse | input | 1 | Sync-pulse video mode |
| burst | input | 1 | Burst video mode |
| eot_pkt | input | 1 | End-of-transmission packets enabled |
| line_end | input | 1 | Lane-aligned line-end mode |
| hactive | input | 16 | Active pixels per line |
| hsync_w | input | 16 | Horizontal sync width, pixels |
| hblank | input | 16 | Horizontal blanking, pixels |
| hsync_off | input | 16 | Horizontal sync offset, pixels |
| hborder | input | 16 | Horizontal border, pixels |
| vactive | input | 16 | Active lines |
| vblank | input | 16 | Vertical blanking, lines |
| vsync_off | input | 16 | Vertical sync offset, lines |
| vsync_w | input | 16 | Vertical sync width, lines |
| vborder | input | 16 | Vertical border, lines |
| lpx | input | 8 | PHY low-power period count |
| hs_prep | input | 8 | PHY HS prepare count |
| hs_zero | input | 8 | PHY HS zero count |
| hs_exit | input | 8 | PHY HS exit count |
| dphy_ovr | input | 16 | Overhead override, 0 selects the computed value |
| done | output | 1 | Result valid pulse |
| hsa_wc | output | 32 | Sync-active byte count, signed |
| hbp_wc | output | 32 | Back-porch byte count, signed |
| hfp_wc | output | 32 | Front-porch byte count, signed |
| vsa_ln | output | 32 | Vertical sync lines, signed |
| vbp_ln | output | 32 | Vertical back-porch lines, signed |
| vfp_ln | output | 32 | Vertical front-porch lines, signed |
| vact_ln | output | 32 | Vertical active lines, signed |
| ps_wc | output | 16 | Pixel-stream word count |
| warn_ovh | output | 1 | Overhead could not be removed |
| err_porch | output | 1 | Porches too small to rebalance |

## Verification
Nine timing sets are used, each compared field by field against an independent model.

- The sync-pulse and non-sync-pulse sets separate the two back-porch formulas.
- Varying `eot_pkt`, `burst` and the lane count exposes each term of the overhead, and a nonzero override shows it replacing the computed value.
- A line-end case with three lanes, and another with four, exercise the rounding and the active-length tail in a non-power-of-two and a power-of-two case.
- Dedicated sets drive the front porch below 2, the back porch below 2, and their sum below 4, so each rebalance branch is taken once.
- One run re-pulses `start` with altered inputs mid-computation to show that it is ignored.

// File: rtl/blank_pkg.sv
package blank_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_DIVF,
        S_DIVB,
        S_ALIGN,
        S_BAL
    } calc_st_t;

    localparam int PKT_OVERHEAD   = 10;
    localparam int PHY_FIXED      = 3;
    localparam int EOT_EXTRA      = 2;
    localparam int BURST_EXTRA    = 6;
    localparam int LINE_END_TRIM  = 2;
    localparam int PORCH_MIN      = 2;
    localparam logic [2:0] FMT_RGB16 = 3'd3;
endpackage

// File: rtl/blank_div.sv
module blank_div #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [DW-1:0] quo,
    output logic          fin
);
    localparam int CW = $clog2(DW + 1);

    logic [DW:0]   rem;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [DW:0]   rsh;

    assign rsh = {rem[DW-1:0], quo[DW-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem  <= '0;
            quo  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !busy) begin
                quo  <= num;
                rem  <= '0;
                cnt  <= CW'(DW);
                busy <= 1'b1;
            end else if (busy) begin
                if (rsh >= {1'b0, den}) begin
                    rem <= rsh - {1'b0, den};
                    quo <= {quo[DW-2:0], 1'b1};
                end else begin
                    rem <= rsh;
                    quo <= {quo[DW-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/blank_prep.sv
module blank_prep
    import blank_pkg::*;
#(
    parameter int TW = 16,
    parameter int PW = 8,
    parameter int RW = 32
) (
    input  logic [2:0]           fmt,
    input  logic [2:0]           lanes,
    input  logic                 sync_pulse,
    input  logic                 burst,
    input  logic                 eot_pkt,
    input  logic [TW-1:0]        hactive,
    input  logic [TW-1:0]        hsync_w,
    input  logic [TW-1:0]        hblank,
    input  logic [TW-1:0]        hsync_off,
    input  logic [TW-1:0]        hborder,
    input  logic [TW-1:0]        vblank,
    input  logic [TW-1:0]        vsync_off,
    input  logic [TW-1:0]        vsync_w,
    input  logic [TW-1:0]        vborder,
    input  logic [PW-1:0]        lpx,
    input  logic [PW-1:0]        hs_prep,
    input  logic [PW-1:0]        hs_zero,
    input  logic [PW-1:0]        hs_exit,
    input  logic [TW-1:0]        dphy_ovr,
    output logic [2:0]           lanes_eff,
    output logic signed [RW-1:0] hsa0,
    output logic signed [RW-1:0] hbp0,
    output logic signed [RW-1:0] hfp0,
    output logic signed [RW-1:0] hfp_px,
    output logic signed [RW-1:0] hbp_px,
    output logic signed [RW-1:0] vbp,
    output logic signed [RW-1:0] vfp,
    output logic signed [RW-1:0] ovh,
    output logic signed [RW-1:0] act_bytes,
    output logic                 fits
);
    logic signed [RW-1:0] b_s, ln_s, hsw_s, phy_sum, extra;

    always_comb begin
        b_s       = (fmt == FMT_RGB16) ? RW'(2) : RW'(3);
        lanes_eff = (lanes >= 3'd1 && lanes <= 3'd4) ? lanes : 3'd4;
        ln_s      = RW'(lanes_eff);
        hsw_s     = RW'(hsync_w);
        hbp_px    = RW'(hblank) - RW'(hsync_off) - hsw_s - RW'(hborder);
        hfp_px    = RW'(hsync_off) - RW'(hborder);
        hsa0      = hsw_s * b_s - RW'(PKT_OVERHEAD);
        hbp0      = (sync_pulse ? hbp_px : hbp_px + hsw_s) * b_s - RW'(PKT_OVERHEAD);
        hfp0      = hfp_px * b_s;
        vbp       = RW'(vblank) - RW'(vsync_off) - RW'(vsync_w) - RW'(vborder);
        vfp       = RW'(vsync_off) - RW'(vborder);
        phy_sum   = RW'(lpx) + RW'(hs_prep) + RW'(hs_zero) + RW'(hs_exit) + RW'(PHY_FIXED);
        extra     = RW'(PKT_OVERHEAD) + (eot_pkt ? RW'(EOT_EXTRA) : RW'(0))
                  + (burst ? RW'(BURST_EXTRA) : RW'(0));
        ovh       = (dphy_ovr != '0) ? RW'(dphy_ovr) : phy_sum * ln_s + extra;
        act_bytes = RW'(hactive) * b_s;
        fits      = (hfp_px >= 0) && (hbp_px >= 0) && ((hfp_px + hbp_px) * b_s > ovh);
    end
endmodule

// File: rtl/dsi_blank_calc.sv
module dsi_blank_calc
    import blank_pkg::*;
#(
    parameter int TW = 16,
    parameter int PW = 8,
    parameter int RW = 32,
    parameter int WCW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           fmt,
    input  logic [2:0]           lanes,
    input  logic                 sync_pulse,
    input  logic                 burst,
    input  logic                 eot_pkt,
    input  logic                 line_end,
    input  logic [TW-1:0]        hactive,
    input  logic [TW-1:0]        hsync_w,
    input  logic [TW-1:0]        hblank,
    input  logic [TW-1:0]        hsync_off,
    input  logic [TW-1:0]        hborder,
    input  logic [TW-1:0]        vactive,
    input  logic [TW-1:0]        vblank,
    input  logic [TW-1:0]        vsync_off,
    input  logic [TW-1:0]        vsync_w,
    input  logic [TW-1:0]        vborder,
    input  logic [PW-1:0]        lpx,
    input  logic [PW-1:0]        hs_prep,
    input  logic [PW-1:0]        hs_zero,
    input  logic [PW-1:0]        hs_exit,
    input  logic [TW-1:0]        dphy_ovr,
    output logic                 done,
    output logic signed [RW-1:0] hsa_wc,
    output logic signed [RW-1:0] hbp_wc,
    output logic signed [RW-1:0] hfp_wc,
    output logic signed [RW-1:0] vsa_ln,
    output logic signed [RW-1:0] vbp_ln,
    output logic signed [RW-1:0] vfp_ln,
    output logic signed [RW-1:0] vact_ln,
    output logic [WCW-1:0]       ps_wc,
    output logic                 warn_ovh,
    output logic                 err_porch
);
    function automatic logic [2:0] fmod(input logic signed [RW-1:0] x, input logic [2:0] ln);
        logic signed [RW-1:0] m;
        m = x % $signed(RW'(3));
        if (m < 0) m = m + RW'(3);
        unique case (ln)
            3'd1:    fmod = 3'd0;
            3'd2:    fmod = {2'b00, x[0]};
            3'd3:    fmod = m[2:0];
            default: fmod = {1'b0, x[1:0]};
        endcase
    endfunction

    function automatic logic signed [RW-1:0] lalign(input logic signed [RW-1:0] x, input logic [2:0] ln);
        logic [2:0] r;
        r = fmod(x, ln);
        lalign = x + RW'((r == 3'd0) ? 3'd0 : ln - r) - RW'(LINE_END_TRIM);
    endfunction

    calc_st_t st, st_nx;

    logic [2:0]           p_lanes;
    logic signed [RW-1:0] p_hsa, p_hbp, p_hfp, p_hfpx, p_hbpx, p_vbp, p_vfp, p_ovh, p_act;
    logic                 p_fits;

    logic signed [RW-1:0] hsa_r, hbp_r, hfp_r, hfpx_r, hbpx_r, ovh_r, vbp_r, vfp_r;
    logic signed [RW-1:0] vsa_r, vact_r, act_r;
    logic [2:0]           lanes_r;
    logic                 fits_r, le_r, warn_r;

    logic                 dv_go, dv_fin;
    logic [RW-1:0]        dv_num, dv_den, dv_quo;

    logic signed [RW-1:0] bal_hfp, bal_hbp;
    logic                 bal_err;

    blank_prep #(.TW(TW), .PW(PW), .RW(RW)) u_prep (
        .fmt(fmt), .lanes(lanes), .sync_pulse(sync_pulse), .burst(burst), .eot_pkt(eot_pkt),
        .hactive(hactive), .hsync_w(hsync_w), .hblank(hblank), .hsync_off(hsync_off),
        .hborder(hborder), .vblank(vblank), .vsync_off(vsync_off), .vsync_w(vsync_w),
        .vborder(vborder), .lpx(lpx), .hs_prep(hs_prep), .hs_zero(hs_zero), .hs_exit(hs_exit),
        .dphy_ovr(dphy_ovr), .lanes_eff(p_lanes), .hsa0(p_hsa), .hbp0(p_hbp), .hfp0(p_hfp),
        .hfp_px(p_hfpx), .hbp_px(p_hbpx), .vbp(p_vbp), .vfp(p_vfp), .ovh(p_ovh),
        .act_bytes(p_act), .fits(p_fits)
    );

    assign dv_go  = ((st == S_LOAD) && fits_r) || ((st == S_DIVF) && dv_fin);
    assign dv_num = (st == S_LOAD) ? $unsigned(ovh_r * hfpx_r) : $unsigned(ovh_r * hbpx_r);
    assign dv_den = $unsigned(hfpx_r + hbpx_r);

    blank_div #(.DW(RW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(dv_go), .num(dv_num), .den(dv_den),
        .quo(dv_quo), .fin(dv_fin)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (start) st_nx = S_LOAD;
            S_LOAD:  st_nx = fits_r ? S_DIVF : S_ALIGN;
            S_DIVF:  if (dv_fin) st_nx = S_DIVB;
            S_DIVB:  if (dv_fin) st_nx = S_ALIGN;
            S_ALIGN: st_nx = S_BAL;
            S_BAL:   st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_comb begin
        bal_hfp = hfp_r;
        bal_hbp = hbp_r;
        bal_err = 1'b0;
        if (hfp_r + hbp_r < RW'(2 * PORCH_MIN)) begin
            bal_err = 1'b1;
        end else if (hfp_r < RW'(PORCH_MIN)) begin
            bal_hbp = hbp_r - (RW'(PORCH_MIN) - hfp_r);
            bal_hfp = RW'(PORCH_MIN);
        end else if (hbp_r < RW'(PORCH_MIN)) begin
            bal_hfp = hfp_r - (RW'(PORCH_MIN) - hbp_r);
            bal_hbp = RW'(PORCH_MIN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {hsa_r, hbp_r, hfp_r, hfpx_r, hbpx_r, ovh_r} <= '0;
            {vbp_r, vfp_r, vsa_r, vact_r, act_r} <= '0;
            lanes_r <= 3'd4;
            {fits_r, le_r, warn_r} <= '0;
            done <= 1'b0;
            {hsa_wc, hbp_wc, hfp_wc, vsa_ln, vbp_ln, vfp_ln, vact_ln} <= '0;
            ps_wc <= '0;
            warn_ovh <= 1'b0;
            err_porch <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                S_IDLE: if (start) begin
                    hsa_r <= p_hsa;  hbp_r <= p_hbp;  hfp_r <= p_hfp;
                    hfpx_r <= p_hfpx; hbpx_r <= p_hbpx; ovh_r <= p_ovh;
                    vbp_r <= p_vbp;  vfp_r <= p_vfp;
                    vsa_r <= RW'(vsync_w); vact_r <= RW'(vactive);
                    act_r <= p_act;  lanes_r <= p_lanes;
                    fits_r <= p_fits; le_r <= line_end; warn_r <= 1'b0;
                end
                S_LOAD: if (!fits_r) warn_r <= 1'b1;
                S_DIVF: if (dv_fin) hfp_r <= hfp_r - $signed(dv_quo);
                S_DIVB: if (dv_fin) hbp_r <= hbp_r - $signed(dv_quo);
                S_ALIGN: if (le_r) begin
                    hsa_r <= lalign(hsa_r, lanes_r);
                    hfp_r <= lalign(hfp_r, lanes_r);
                    hbp_r <= lalign(hbp_r, lanes_r) - RW'(fmod(act_r + RW'(2), lanes_r));
                end
                S_BAL: begin
                    done      <= 1'b1;
                    hsa_wc    <= hsa_r;
                    hfp_wc    <= bal_hfp;
                    hbp_wc    <= bal_hbp;
                    err_porch <= bal_err;
                    warn_ovh  <= warn_r;
                    vsa_ln    <= vsa_r;
                    vbp_ln    <= vbp_r;
                    vfp_ln    <= vfp_r;
                    vact_ln   <= vact_r;
                    ps_wc     <= act_r[WCW-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/blank_calc_chk.sv
module blank_calc_chk #(
    parameter int RW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 done,
    input logic                 err_porch,
    input logic signed [RW-1:0] hsa_wc,
    input logic signed [RW-1:0] hbp_wc,
    input logic signed [RW-1:0] hfp_wc
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hfp_wc) && $stable(hbp_wc) && $stable(hsa_wc))); // R9
    AST_PORCH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err_porch) |-> (hfp_wc >= 2 && hbp_wc >= 2)); // R7
    AST_ERR_SMALL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_porch) |-> (hfp_wc + hbp_wc < 4)); // R7
endmodule

bind dsi_blank_calc blank_calc_chk #(.RW(RW)) u_blank_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .err_porch(err_porch),
    .hsa_wc(hsa_wc), .hbp_wc(hbp_wc), .hfp_wc(hfp_wc)
);

// File: tb/test_dsi_blank_calc.sv
module test_dsi_blank_calc;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        string  tag;
        longint hsa, hbp, hfp, vsa, vbp, vfp, vact, pswc;
        bit     warn, err;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [2:0] fmt, lanes;
    logic sync_pulse, burst, eot_pkt, line_end;
    logic [15:0] hactive, hsync_w, hblank, hsync_off, hborder;
    logic [15:0] vactive, vblank, vsync_off, vsync_w, vborder, dphy_ovr;
    logic [7:0] lpx, hs_prep, hs_zero, hs_exit;
    logic done, warn_ovh, err_porch;
    logic signed [31:0] hsa_wc, hbp_wc, hfp_wc, vsa_ln, vbp_ln, vfp_ln, vact_ln;
    logic [15:0] ps_wc;

    int n_vec = 0, n_bad = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dsi_blank_calc i_dsi_blank_calc (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt), .lanes(lanes),
        .sync_pulse(sync_pulse), .burst(burst), .eot_pkt(eot_pkt), .line_end(line_end),
        .hactive(hactive), .hsync_w(hsync_w), .hblank(hblank), .hsync_off(hsync_off),
        .hborder(hborder), .vactive(vactive), .vblank(vblank), .vsync_off(vsync_off),
        .vsync_w(vsync_w), .vborder(vborder), .lpx(lpx), .hs_prep(hs_prep),
        .hs_zero(hs_zero), .hs_exit(hs_exit), .dphy_ovr(dphy_ovr), .done(done),
        .hsa_wc(hsa_wc), .hbp_wc(hbp_wc), .hfp_wc(hfp_wc), .vsa_ln(vsa_ln),
        .vbp_ln(vbp_ln), .vfp_ln(vfp_ln), .vact_ln(vact_ln), .ps_wc(ps_wc),
        .warn_ovh(warn_ovh), .err_porch(err_porch)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint al(input longint x, input longint l);
        longint r;
        r = ((x % l) + l) % l;
        return x + ((r == 0) ? 0 : l - r) - 2;
    endfunction

    function automatic exp_t model(input string tag);
        exp_t e;
        longint b, l, hbp, hfp, ovh, s;
        e.tag = tag;
        b = (fmt == 3'd3) ? 2 : 3;                          // R1
        l = (lanes >= 1 && lanes <= 4) ? longint'(lanes) : 4;
        hbp = longint'(hblank) - hsync_off - hsync_w - hborder;
        hfp = longint'(hsync_off) - hborder;
        e.hsa = longint'(hsync_w) * b - 10;                 // R3
        e.hbp = sync_pulse ? hbp * b - 10 : (hbp + hsync_w) * b - 10;
        e.hfp = hfp * b;
        ovh = (dphy_ovr != 0) ? longint'(dphy_ovr)          // R4
            : (longint'(lpx) + hs_prep + hs_zero + hs_exit + 3) * l + 10
              + (eot_pkt ? 2 : 0) + (burst ? 6 : 0);
        e.warn = 1'b0;
        if (hfp >= 0 && hbp >= 0 && (hfp + hbp) * b > ovh) begin   // R5
            e.hfp -= ovh * hfp / (hfp + hbp);
            e.hbp -= ovh * hbp / (hfp + hbp);
        end else e.warn = 1'b1;
        if (line_end) begin                                  // R6
            e.hsa = al(e.hsa, l);
            e.hfp = al(e.hfp, l);
            e.hbp = al(e.hbp, l) - ((longint'(hactive) * b + 2) % l);
        end
        e.err = 1'b0;
        s = e.hfp + e.hbp;                                   // R7
        if (s < 4) e.err = 1'b1;
        else if (e.hfp < 2) begin e.hbp -= 2 - e.hfp; e.hfp = 2; end
        else if (e.hbp < 2) begin e.hfp -= 2 - e.hbp; e.hbp = 2; end
        e.vsa  = vsync_w;                                    // R2
        e.vbp  = longint'(vblank) - vsync_off - vsync_w - vborder;
        e.vfp  = longint'(vsync_off) - vborder;
        e.vact = vactive;
        e.pswc = (longint'(hactive) * b) & 64'hFFFF;         // R8
        return e;
    endfunction

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb.size() == 0) begin
                    n_vec++; n_bad++;
                    $display("FAIL R9 unexpected done actual=1 expected=0");
                end else begin
                    e = sb.pop_front();
                    chk(e.tag, "hsa_wc", hsa_wc, e.hsa);
                    chk(e.tag, "hbp_wc", hbp_wc, e.hbp);
                    chk(e.tag, "hfp_wc", hfp_wc, e.hfp);
                    chk("R7", "err_porch", longint'(err_porch), longint'(e.err));
                    chk("R5", "warn_ovh", longint'(warn_ovh), longint'(e.warn));
                    chk("R2", "vsa_ln", vsa_ln, e.vsa);
                    chk("R2", "vbp_ln", vbp_ln, e.vbp);
                    chk("R2", "vfp_ln", vfp_ln, e.vfp);
                    chk("R2", "vact_ln", vact_ln, e.vact);
                    chk("R8", "ps_wc", longint'(ps_wc), e.pswc);
                end
            end
        end
    end

    task automatic apply(input string tag, input bit glitch);
        logic [15:0] keep;
        sb.push_back(model(tag));
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (glitch) begin                                    // R9 ignored start
            repeat (5) @(negedge clk);
            keep = hblank; hblank = hblank + 16'd50; start = 1'b1;
            @(negedge clk); start = 1'b0;
            while (sb.size() > 0) @(negedge clk);
            hblank = keep;
        end else begin
            while (sb.size() > 0) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic base();
        fmt = 3'd0; lanes = 3'd4; sync_pulse = 1'b1; burst = 1'b0; eot_pkt = 1'b1;
        line_end = 1'b0; hactive = 16'd1080; hsync_w = 16'd8; hblank = 16'd100;
        hsync_off = 16'd40; hborder = 16'd0; vactive = 16'd1920; vblank = 16'd40;
        vsync_off = 16'd12; vsync_w = 16'd4; vborder = 16'd0; lpx = 8'd5;
        hs_prep = 8'd6; hs_zero = 8'd10; hs_exit = 8'd11; dphy_ovr = 16'd0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : driver
        base();
        repeat (3) @(negedge clk);
        chk("R10", "done at reset", longint'(done), 0);
        chk("R10", "hfp_wc at reset", hfp_wc, 0);
        chk("R10", "err_porch at reset", longint'(err_porch), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 R4 R5: sync-pulse, EoT on, four lanes
        apply("R3", 1'b0);
        // R3 R4: non-sync back porch, burst term, two lanes, no EoT
        sync_pulse = 1'b0; burst = 1'b1; eot_pkt = 1'b0; lanes = 3'd2;
        hblank = 16'd160; hsync_off = 16'd60; hborder = 16'd2;
        vborder = 16'd1;
        apply("R4", 1'b0);
        // R6 line-end, three lanes, packed 18-bit format
        base(); fmt = 3'd2; lanes = 3'd3; line_end = 1'b1; hactive = 16'd721;
        apply("R6", 1'b0);
        // R1 16-bit format with override, one lane
        base(); fmt = 3'd3; lanes = 3'd1; dphy_ovr = 16'd50;
        apply("R1", 1'b0);
        // R5 R7: overhead too large and porch sum below minimum
        base(); hblank = 16'd8; hsync_off = 16'd2; hsync_w = 16'd4;
        apply("R5", 1'b0);
        // R7 front porch driven below 2
        base(); hblank = 16'd39; hsync_off = 16'd1; dphy_ovr = 16'd80;
        apply("R7", 1'b0);
        // R7 back porch driven below 2
        base(); hblank = 16'd48; hsync_off = 16'd40; dphy_ovr = 16'd20;
        apply("R7", 1'b0);
        // R1 unknown format code treated as 3 bytes
        base(); fmt = 3'd6; sync_pulse = 1'b0;
        apply("R1", 1'b0);
        // R6 R9: line-end, four lanes, repeated start mid-run ignored
        base(); line_end = 1'b1; hactive = 16'd1083; burst = 1'b1;
        apply("R6", 1'b1);
        chk("R9", "pending results", longint'(sb.size()), 0);
        repeat (10) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule